// File: doc/BRIEF.md
# Block-Copy DMA Engine

This block moves data between a main memory and an auxiliary memory in 32-byte chunks, in either direction. Software programs a main address, an auxiliary address and a length with a direction bit. Writing the length starts the copy. Every register can be written as two 16-bit halves or as one 32-bit word. The engine owns two memory request ports, one per memory. Each port carries a whole 256-bit chunk and an aligned address over a valid/ready handshake. A read on one port completes before the matching write is issued on the other port.

When the copy finishes, a pending-interrupt bit is set. That bit reaches the interrupt pin only while the mask bit is set. Two special cases are decided at the moment the copy starts:

- **Out-of-range auxiliary address.** The auxiliary memory is never touched. A read from it turns into a zero fill of the main range. A write to it is dropped silently.
- **Fixed start-up address pair.** This pair sends four times the programmed length from main memory to a separate instruction-memory write port.

Top module: `blkcopy_dma`

## Requirements
- R1: Both address registers and the length field hold only bits 25:5. Bits 4:0 always read as zero, and the length register also holds bit 31. Register indices used below: 0/1 main address high/low, 2/3 auxiliary address high/low, 4/5 length high/low, 6/7/8 main address, auxiliary address and length as 32-bit words, 9 control, 10 size, 11 mode.
- R2: A write to a high half (indices 0, 2, 4) stores data bits 9:0 into register bits 25:16. The length high half also stores data bit 15 as the direction. A write to a low half (1, 3, 5) stores data bits 15:5 and forces bits 4:0 to zero. In both cases the other half keeps its value.
- R3: Only a write to index 5 or index 8 starts a copy. No other write starts one.
- R4: With direction 0, each chunk is read from main memory at the main address and written to auxiliary memory at the auxiliary address. After each chunk, both addresses advance by 32 and the length drops by 32. The direction bit is kept.
- R5: With direction 1, each chunk is read from the auxiliary address and written to the main address. The same address and length steps apply.
- R6: When the length reaches zero, busy (control bit 2) clears and the pending bit (control bit 1) sets. The interrupt pin is high only while pending and mask (control bit 0) are both 1.
- R7: Writing 1 to control bit 1 clears the pending bit. Control bit 0 is read/write.
- R8: If the auxiliary address is at or above the auxiliary size and the direction is 1, the main range is filled with zero chunks and the auxiliary port stays idle. The copy then completes with pending set and the length at zero.
- R9: If the auxiliary address is at or above the auxiliary size and the direction is 0, the start is dropped. There is no memory traffic, no busy, no pending, and the registers are unchanged.
- R10: Main address 0x0100_0000 with auxiliary address 0 and direction 0 redirects the copy. The engine reads length×4 bytes from main memory and writes them to the instruction port at addresses 0, 32, 64 and so on. The length reads 0 from the start, the main address advances by 32 per chunk, and pending sets at the end.
- R11: The size register (index 10) reads back its low 16 bits. The mode register (index 11) always reads 1.
- R12: While busy, writes to the address and length registers are ignored and cannot start a copy.
- R13: At most one memory port shows valid at a time. A request holds its address until it is accepted, and a chunk's read completes before its write.
- R14: A start with a length of zero completes at once with pending set and no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_idx) |
| irq_o | output | 1 | Masked completion interrupt |
| mm_valid | output | 1 | Main memory request valid |
| mm_we | output | 1 | Main memory request is a write |
| mm_addr | output | 26 | Main memory chunk address |
| mm_wdata | output | 256 | Main memory write chunk |
| mm_ready | input | 1 | Main memory accepts request |
| mm_rvalid | input | 1 | Main memory read data valid |
| mm_rdata | input | 256 | Main memory read chunk |
| ax_valid | output | 1 | Auxiliary memory request valid |
| ax_we | output | 1 | Auxiliary memory request is a write |
| ax_addr | output | 26 | Auxiliary memory chunk address |
| ax_wdata | output | 256 | Auxiliary memory write chunk |
| ax_ready | input | 1 | Auxiliary memory accepts request |
| ax_rvalid | input | 1 | Auxiliary memory read data valid |
| ax_rdata | input | 256 | Auxiliary memory read chunk |
| im_valid | output | 1 | Instruction memory write valid |
| im_addr | output | 26 | Instruction memory chunk address |
| im_wdata | output | 256 | Instruction memory write chunk |
| im_ready | input | 1 | Instruction memory accepts write |

## Verification
The bench checks half-register writes to catch three faults: a design that starts a copy on a length high-half write, one that drops the preserved half, and one that keeps low address bits. It also aims at the start-time decisions. An engine that checks the auxiliary range after it has begun would emit auxiliary traffic or raise an interrupt on a dropped write. An engine that ignores the fixed address pair would copy to auxiliary memory instead of the instruction port, and with a quarter of the chunks. Finally, the bench writes a new address during a running copy and stalls each port with ready patterns. A design that lets the write through, or that changes an address before acceptance, ends with the wrong final address or corrupted data.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_RD    = 2'd1,
        XS_RWAIT = 2'd2,
        XS_WR    = 2'd3
    } xstate_e;

    typedef enum logic [1:0] {
        XM_NORM = 2'd0,
        XM_ZERO = 2'd1,
        XM_IMEM = 2'd2
    } xmode_e;

    localparam logic [3:0] RI_MAIN_HI = 4'd0;
    localparam logic [3:0] RI_MAIN_LO = 4'd1;
    localparam logic [3:0] RI_AUX_HI  = 4'd2;
    localparam logic [3:0] RI_AUX_LO  = 4'd3;
    localparam logic [3:0] RI_LEN_HI  = 4'd4;
    localparam logic [3:0] RI_LEN_LO  = 4'd5;
    localparam logic [3:0] RI_MAIN_W  = 4'd6;
    localparam logic [3:0] RI_AUX_W   = 4'd7;
    localparam logic [3:0] RI_LEN_W   = 4'd8;
    localparam logic [3:0] RI_CTRL    = 4'd9;
    localparam logic [3:0] RI_SIZE    = 4'd10;
    localparam logic [3:0] RI_MODE    = 4'd11;

endpackage

// File: rtl/blkdma_hostif.sv
module blkdma_hostif
    import blkdma_pkg::*;
#(
    parameter int AW = 26,
    parameter int CB = 32
) (
    input  logic                 we,
    input  logic [3:0]           idx,
    input  logic [31:0]          wdata,
    input  logic [AW-$clog2(CB)-1:0] cur_main,
    input  logic [AW-$clog2(CB)-1:0] cur_aux,
    input  logic [AW-$clog2(CB)-1:0] cur_len,
    input  logic                 cur_dir,
    input  logic                 busy,
    input  logic                 mask,
    input  logic                 pend,
    input  logic [15:0]          size,
    output logic                 ld_en,
    output logic [AW-$clog2(CB)-1:0] ld_main,
    output logic [AW-$clog2(CB)-1:0] ld_aux,
    output logic [AW-$clog2(CB)-1:0] ld_len,
    output logic                 ld_dir,
    output logic                 start,
    output logic                 mask_we,
    output logic                 pend_clr,
    output logic                 size_we,
    output logic [31:0]          rdata
);
    localparam int OB  = $clog2(CB);
    localparam int FW  = AW - OB;
    localparam int LOW = 16 - OB;
    localparam int HIW = FW - LOW;

    logic unused_wbits;
    assign unused_wbits = ^wdata[30:AW];

    always_comb begin
        ld_en    = 1'b0;
        ld_main  = cur_main;
        ld_aux   = cur_aux;
        ld_len   = cur_len;
        ld_dir   = cur_dir;
        start    = 1'b0;
        mask_we  = 1'b0;
        pend_clr = 1'b0;
        size_we  = 1'b0;
        if (we && !busy) begin
            case (idx)
                RI_MAIN_HI: begin ld_en = 1'b1; ld_main[FW-1:LOW] = wdata[HIW-1:0]; end
                RI_MAIN_LO: begin ld_en = 1'b1; ld_main[LOW-1:0]  = wdata[15:OB];  end
                RI_AUX_HI:  begin ld_en = 1'b1; ld_aux[FW-1:LOW]  = wdata[HIW-1:0]; end
                RI_AUX_LO:  begin ld_en = 1'b1; ld_aux[LOW-1:0]   = wdata[15:OB];  end
                RI_LEN_HI: begin
                    ld_en = 1'b1;
                    ld_len[FW-1:LOW] = wdata[HIW-1:0];
                    ld_dir = wdata[15];
                end
                RI_LEN_LO: begin ld_en = 1'b1; ld_len[LOW-1:0] = wdata[15:OB]; start = 1'b1; end
                RI_MAIN_W: begin ld_en = 1'b1; ld_main = wdata[AW-1:OB]; end
                RI_AUX_W:  begin ld_en = 1'b1; ld_aux  = wdata[AW-1:OB]; end
                RI_LEN_W: begin
                    ld_en  = 1'b1;
                    ld_len = wdata[AW-1:OB];
                    ld_dir = wdata[31];
                    start  = 1'b1;
                end
                default: ;
            endcase
        end
        if (we) begin
            case (idx)
                RI_CTRL: begin mask_we = 1'b1; pend_clr = wdata[1]; end
                RI_SIZE: size_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RI_MAIN_HI: rdata[HIW-1:0] = cur_main[FW-1:LOW];
            RI_MAIN_LO: rdata[15:OB]   = cur_main[LOW-1:0];
            RI_AUX_HI:  rdata[HIW-1:0] = cur_aux[FW-1:LOW];
            RI_AUX_LO:  rdata[15:OB]   = cur_aux[LOW-1:0];
            RI_LEN_HI: begin
                rdata[HIW-1:0] = cur_len[FW-1:LOW];
                rdata[15]      = cur_dir;
            end
            RI_LEN_LO:  rdata[15:OB]   = cur_len[LOW-1:0];
            RI_MAIN_W:  rdata[AW-1:OB] = cur_main;
            RI_AUX_W:   rdata[AW-1:OB] = cur_aux;
            RI_LEN_W: begin
                rdata[AW-1:OB] = cur_len;
                rdata[31]      = cur_dir;
            end
            RI_CTRL:    rdata[2:0]  = {busy, pend, mask};
            RI_SIZE:    rdata[15:0] = size;
            RI_MODE:    rdata[0]    = 1'b1;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkdma_xfer.sv
module blkdma_xfer
    import blkdma_pkg::*;
#(
    parameter int AW = 26,
    parameter int CB = 32,
    parameter int unsigned AUX_BYTES  = 32'h0100_0000,
    parameter int unsigned MAGIC_MAIN = 32'h0100_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [AW-$clog2(CB)-1:0] ld_main,
    input  logic [AW-$clog2(CB)-1:0] ld_aux,
    input  logic [AW-$clog2(CB)-1:0] ld_len,
    input  logic                 ld_dir,
    input  logic                 start,
    output logic [AW-$clog2(CB)-1:0] main_o,
    output logic [AW-$clog2(CB)-1:0] aux_o,
    output logic [AW-$clog2(CB)-1:0] len_o,
    output logic                 dir_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 mm_valid,
    output logic                 mm_we,
    output logic [AW-1:0]        mm_addr,
    output logic [CB*8-1:0]      mm_wdata,
    input  logic                 mm_ready,
    input  logic                 mm_rvalid,
    input  logic [CB*8-1:0]      mm_rdata,
    output logic                 ax_valid,
    output logic                 ax_we,
    output logic [AW-1:0]        ax_addr,
    output logic [CB*8-1:0]      ax_wdata,
    input  logic                 ax_ready,
    input  logic                 ax_rvalid,
    input  logic [CB*8-1:0]      ax_rdata,
    output logic                 im_valid,
    output logic [AW-1:0]        im_addr,
    output logic [CB*8-1:0]      im_wdata,
    input  logic                 im_ready
);
    localparam int OB  = $clog2(CB);
    localparam int FW  = AW - OB;
    localparam int RW  = FW + 2;
    localparam int CW  = CB * 8;
    localparam int AW1 = AW + 1;
    localparam logic [AW:0]   AUX_L   = AW1'(AUX_BYTES);
    localparam logic [FW-1:0] MAGIC_F = FW'(MAGIC_MAIN >> OB);

    typedef struct packed {
        xstate_e       st;
        xmode_e        mode;
        logic [FW-1:0] main;
        logic [FW-1:0] aux;
        logic [FW-1:0] len;
        logic          dir;
        logic [FW-1:0] imx;
        logic [RW-1:0] rem;
        logic [CW-1:0] dat;
        logic          done;
    } xreg_t;

    xreg_t r_q, r_d;
    logic src_main, dst_main, dst_aux;
    logic src_rdy, src_rv, dst_rdy;
    logic [CW-1:0] src_rd;
    logic [RW-1:0] togo;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        src_main = !(r_q.mode == XM_NORM && r_q.dir);
        dst_aux  = (r_q.mode == XM_NORM) && !r_q.dir;
        dst_main = (r_q.mode == XM_ZERO) || (r_q.mode == XM_NORM && r_q.dir);
        src_rdy  = src_main ? mm_ready  : ax_ready;
        src_rv   = src_main ? mm_rvalid : ax_rvalid;
        src_rd   = src_main ? mm_rdata  : ax_rdata;
        dst_rdy  = dst_main ? mm_ready : (dst_aux ? ax_ready : im_ready);
        togo     = (r_q.mode == XM_IMEM) ? r_q.rem : RW'(r_q.len);
        case (r_q.st)
            XS_IDLE: begin
                if (ld_en) begin
                    r_d.main = ld_main;
                    r_d.aux  = ld_aux;
                    r_d.len  = ld_len;
                    r_d.dir  = ld_dir;
                end
                if (start) begin
                    if (!ld_dir && ld_main == MAGIC_F && ld_aux == '0) begin
                        r_d.mode = XM_IMEM;
                        r_d.rem  = {ld_len, 2'b00};
                        r_d.len  = '0;
                        r_d.imx  = '0;
                        if (ld_len == '0) r_d.done = 1'b1;
                        else              r_d.st   = XS_RD;
                    end else if ({1'b0, ld_aux, {OB{1'b0}}} >= AUX_L) begin
                        if (ld_dir) begin
                            r_d.mode = XM_ZERO;
                            if (ld_len == '0) r_d.done = 1'b1;
                            else              r_d.st   = XS_WR;
                        end
                    end else begin
                        r_d.mode = XM_NORM;
                        if (ld_len == '0) r_d.done = 1'b1;
                        else              r_d.st   = XS_RD;
                    end
                end
            end
            XS_RD: if (src_rdy) r_d.st = XS_RWAIT;
            XS_RWAIT: begin
                if (src_rv) begin
                    r_d.dat = src_rd;
                    r_d.st  = XS_WR;
                end
            end
            XS_WR: begin
                if (dst_rdy) begin
                    r_d.main = r_q.main + 1'b1;
                    if (r_q.mode == XM_NORM) r_d.aux = r_q.aux + 1'b1;
                    if (r_q.mode == XM_IMEM) begin
                        r_d.imx = r_q.imx + 1'b1;
                        r_d.rem = r_q.rem - 1'b1;
                    end else begin
                        r_d.len = r_q.len - 1'b1;
                    end
                    if (togo == RW'(1)) begin
                        r_d.st   = XS_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = (r_q.mode == XM_ZERO) ? XS_WR : XS_RD;
                    end
                end
            end
            default: r_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign main_o   = r_q.main;
    assign aux_o    = r_q.aux;
    assign len_o    = r_q.len;
    assign dir_o    = r_q.dir;
    assign busy_o   = (r_q.st != XS_IDLE);
    assign done_o   = r_q.done;

    assign mm_valid = (r_q.st == XS_RD && src_main) || (r_q.st == XS_WR && dst_main);
    assign mm_we    = (r_q.st == XS_WR);
    assign mm_addr  = {r_q.main, {OB{1'b0}}};
    assign mm_wdata = (r_q.mode == XM_ZERO) ? '0 : r_q.dat;
    assign ax_valid = (r_q.st == XS_RD && !src_main) || (r_q.st == XS_WR && dst_aux);
    assign ax_we    = (r_q.st == XS_WR);
    assign ax_addr  = {r_q.aux, {OB{1'b0}}};
    assign ax_wdata = r_q.dat;
    assign im_valid = (r_q.st == XS_WR) && (r_q.mode == XM_IMEM);
    assign im_addr  = {r_q.imx, {OB{1'b0}}};
    assign im_wdata = r_q.dat;

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mm_valid, ax_valid, im_valid}));                                  // R13
    AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_valid && !mm_ready) |=> (mm_valid && $stable(mm_addr) && $stable(mm_we))); // R13
    AST_AX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && !ax_ready) |=> (ax_valid && $stable(ax_addr) && $stable(ax_we))); // R13
    AST_AUX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ax_valid |-> ({1'b0, ax_addr} < AUX_L));                                     // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                         // R6
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == XS_WR && dst_rdy && r_q.mode == XM_NORM)
            |=> (len_o == FW'($past(len_o) - 1'b1) && $stable(dir_o)));             // R4
endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma
    import blkdma_pkg::*;
#(
    parameter int AW = 26,
    parameter int CB = 32,
    parameter int unsigned AUX_BYTES  = 32'h0100_0000,
    parameter int unsigned MAGIC_MAIN = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o,
    output logic              mm_valid,
    output logic              mm_we,
    output logic [AW-1:0]     mm_addr,
    output logic [CB*8-1:0]   mm_wdata,
    input  logic              mm_ready,
    input  logic              mm_rvalid,
    input  logic [CB*8-1:0]   mm_rdata,
    output logic              ax_valid,
    output logic              ax_we,
    output logic [AW-1:0]     ax_addr,
    output logic [CB*8-1:0]   ax_wdata,
    input  logic              ax_ready,
    input  logic              ax_rvalid,
    input  logic [CB*8-1:0]   ax_rdata,
    output logic              im_valid,
    output logic [AW-1:0]     im_addr,
    output logic [CB*8-1:0]   im_wdata,
    input  logic              im_ready
);
    localparam int FW = AW - $clog2(CB);

    typedef struct packed {
        logic        mask;
        logic        pend;
        logic [15:0] size;
    } treg_t;

    treg_t t_q, t_d;

    logic [FW-1:0] cur_main, cur_aux, cur_len, ld_main, ld_aux, ld_len;
    logic cur_dir, ld_dir, ld_en, start, busy, done;
    logic mask_we, pend_clr, size_we;

    blkdma_hostif #(.AW(AW), .CB(CB)) u_host (
        .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
        .cur_main(cur_main), .cur_aux(cur_aux), .cur_len(cur_len), .cur_dir(cur_dir),
        .busy(busy), .mask(t_q.mask), .pend(t_q.pend), .size(t_q.size),
        .ld_en(ld_en), .ld_main(ld_main), .ld_aux(ld_aux), .ld_len(ld_len), .ld_dir(ld_dir),
        .start(start), .mask_we(mask_we), .pend_clr(pend_clr), .size_we(size_we),
        .rdata(reg_rdata)
    );

    blkdma_xfer #(.AW(AW), .CB(CB), .AUX_BYTES(AUX_BYTES), .MAGIC_MAIN(MAGIC_MAIN)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_main(ld_main), .ld_aux(ld_aux), .ld_len(ld_len), .ld_dir(ld_dir),
        .start(start),
        .main_o(cur_main), .aux_o(cur_aux), .len_o(cur_len), .dir_o(cur_dir),
        .busy_o(busy), .done_o(done),
        .mm_valid(mm_valid), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_ready(mm_ready), .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
        .ax_valid(ax_valid), .ax_we(ax_we), .ax_addr(ax_addr), .ax_wdata(ax_wdata),
        .ax_ready(ax_ready), .ax_rvalid(ax_rvalid), .ax_rdata(ax_rdata),
        .im_valid(im_valid), .im_addr(im_addr), .im_wdata(im_wdata), .im_ready(im_ready)
    );

    always_comb begin
        t_d = t_q;
        if (mask_we)  t_d.mask = reg_wdata[0];
        if (size_we)  t_d.size = reg_wdata[15:0];
        if (pend_clr) t_d.pend = 1'b0;
        if (done)     t_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq_o = t_q.pend & t_q.mask;

    AST_PEND_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> t_q.pend);                                      // R6
    AST_LOCK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ld_en && !start));                            // R12
endmodule

// File: tb/sim_blkcopy_dma.sv
`timescale 1ns/1ps
module sim_blkcopy_dma;
    localparam logic [3:0] I_MAIN_HI = 4'd0, I_MAIN_LO = 4'd1, I_AUX_HI = 4'd2, I_AUX_LO = 4'd3;
    localparam logic [3:0] I_LEN_HI = 4'd4, I_LEN_LO = 4'd5, I_MAIN_W = 4'd6, I_AUX_W = 4'd7;
    localparam logic [3:0] I_LEN_W = 4'd8, I_CTRL = 4'd9, I_SIZE = 4'd10, I_MODE = 4'd11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq_o;
    logic mm_valid, mm_we, ax_valid, ax_we, im_valid;
    logic [25:0] mm_addr, ax_addr, im_addr;
    logic [255:0] mm_wdata, ax_wdata, im_wdata;
    logic mm_ready = 1'b0, ax_ready = 1'b0, im_ready = 1'b0;
    logic mm_rvalid = 1'b0, ax_rvalid = 1'b0;
    logic [255:0] mm_rdata = '0, ax_rdata = '0;

    logic [255:0] mmem [0:63];
    logic [255:0] amem [0:63];
    logic [255:0] imem [0:63];
    int mm_rd_n = 0, mm_wr_n = 0, ax_rd_n = 0, ax_wr_n = 0, im_wr_n = 0, multi_n = 0;
    int checks = 0, fails = 0;
    int unsigned cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    blkcopy_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o),
        .mm_valid(mm_valid), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_ready(mm_ready), .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
        .ax_valid(ax_valid), .ax_we(ax_we), .ax_addr(ax_addr), .ax_wdata(ax_wdata),
        .ax_ready(ax_ready), .ax_rvalid(ax_rvalid), .ax_rdata(ax_rdata),
        .im_valid(im_valid), .im_addr(im_addr), .im_wdata(im_wdata), .im_ready(im_ready)
    );

    // memory models with stalling ready patterns
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mm_ready  <= ~mm_ready;
        ax_ready  <= (cyc[1:0] != 2'd0);
        im_ready  <= (cyc[2:0] != 3'd3);
        mm_rvalid <= 1'b0;
        ax_rvalid <= 1'b0;
        if (mm_valid && mm_ready) begin
            if (mm_we) begin mmem[mm_addr[10:5]] <= mm_wdata; mm_wr_n <= mm_wr_n + 1; end
            else begin mm_rvalid <= 1'b1; mm_rdata <= mmem[mm_addr[10:5]]; mm_rd_n <= mm_rd_n + 1; end
        end
        if (ax_valid && ax_ready) begin
            if (ax_we) begin amem[ax_addr[10:5]] <= ax_wdata; ax_wr_n <= ax_wr_n + 1; end
            else begin ax_rvalid <= 1'b1; ax_rdata <= amem[ax_addr[10:5]]; ax_rd_n <= ax_rd_n + 1; end
        end
        if (im_valid && im_ready) begin
            imem[im_addr[10:5]] <= im_wdata;
            im_wr_n <= im_wr_n + 1;
        end
    end

    always @(negedge clk) begin
        if ((int'(mm_valid) + int'(ax_valid) + int'(im_valid)) > 1) multi_n <= multi_n + 1;
    end

    function automatic logic [255:0] pat(input int s);
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'h5A00_0000 + s * 32'h0001_0101 + k;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_w(input string tag, input logic [255:0] got, input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int n = 0; n < 4000; n++) begin
            rd(I_CTRL, c);
            if (!c[2]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(I_CTRL, v);   chk("R6 reset control", v, 32'h0);
        rd(I_MODE, v);   chk("R11 mode reads 1", v, 32'h1);
        rd(I_MAIN_W, v); chk("R1 reset main", v, 32'h0);
        rd(I_LEN_W, v);  chk("R1 reset length", v, 32'h0);
        chk("R6 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_halves();
        logic [31:0] v;
        int t0;
        t0 = mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n;
        wr(I_MAIN_HI, 32'h0000_FFFF);
        rd(I_MAIN_HI, v); chk("R2 main high keeps 10 bits", v, 32'h3FF);
        wr(I_MAIN_LO, 32'h0000_1234);
        rd(I_MAIN_LO, v); chk("R2 main low clears 4:0", v, 32'h1220);
        rd(I_MAIN_W, v);  chk("R1 main word", v, 32'h03FF_1220);
        wr(I_LEN_HI, 32'h0000_8FFF);
        rd(I_LEN_HI, v);  chk("R2 length high with dir", v, 32'h0000_83FF);
        rd(I_LEN_W, v);   chk("R2 length word", v, 32'h83FF_0000);
        wr(I_AUX_W, 32'hFFFF_FFFF);
        rd(I_AUX_W, v);   chk("R1 aux word mask", v, 32'h03FF_FFE0);
        wr(I_AUX_LO, 32'h0);
        rd(I_AUX_W, v);   chk("R2 aux high preserved", v, 32'h03FF_0000);
        repeat (3) @(negedge clk);
        rd(I_CTRL, v);    chk("R3 no start from other writes", v, 32'h0);
        chk("R3 no traffic", mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n - t0, 0);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        int t0;
        wr(I_MAIN_W, 32'h0);
        wr(I_AUX_W, 32'h0);
        t0 = mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n;
        wr(I_LEN_W, 32'h0);
        repeat (2) @(negedge clk);
        rd(I_CTRL, v);  chk("R14 zero length pends at once", v, 32'h2);
        chk("R14 zero length no traffic", mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n - t0, 0);
        chk("R6 irq masked off", {31'b0, irq_o}, 32'h0);
        wr(I_CTRL, 32'h2);
        rd(I_CTRL, v);  chk("R7 write-one clears pending", v, 32'h0);
        wr(I_CTRL, 32'h1);
        rd(I_CTRL, v);  chk("R7 mask readback", v, 32'h1);
    endtask

    task automatic t_main_to_aux();
        logic [31:0] v;
        int r0, w0;
        for (int k = 2; k < 5; k++) mmem[k] = pat(k);
        for (int k = 8; k < 11; k++) amem[k] = '0;
        r0 = mm_rd_n; w0 = ax_wr_n;
        wr(I_MAIN_W, 32'h0000_0040);
        wr(I_AUX_W, 32'h0000_0100);
        wr(I_LEN_W, 32'h0000_0060);
        rd(I_CTRL, v);  chk("R12 busy readable", v & 32'h4, 32'h4);
        wr(I_MAIN_W, 32'h0000_07E0);
        wait_idle();
        for (int k = 0; k < 3; k++) chk_w("R4 aux chunk data", amem[8 + k], pat(2 + k));
        rd(I_MAIN_W, v); chk("R12 write while busy ignored; R4 main step", v, 32'h0000_00A0);
        rd(I_AUX_W, v);  chk("R4 aux step", v, 32'h0000_0160);
        rd(I_LEN_W, v);  chk("R4 length to zero", v, 32'h0);
        rd(I_CTRL, v);   chk("R6 done status", v, 32'h3);
        chk("R6 irq with mask", {31'b0, irq_o}, 32'h1);
        chk("R4 main reads", mm_rd_n - r0, 3);
        chk("R4 aux writes", ax_wr_n - w0, 3);
        wr(I_CTRL, 32'h2);
        chk("R7 irq drops after clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_aux_to_main();
        logic [31:0] v;
        amem[20] = pat(40); amem[21] = pat(41);
        mmem[16] = '0; mmem[17] = '0;
        wr(I_MAIN_W, 32'h0000_0200);
        wr(I_AUX_W, 32'h0000_0280);
        wr(I_LEN_W, 32'h8000_0040);
        wait_idle();
        chk_w("R5 main chunk 0", mmem[16], pat(40));
        chk_w("R5 main chunk 1", mmem[17], pat(41));
        rd(I_LEN_W, v); chk("R5 direction kept", v, 32'h8000_0000);
        rd(I_CTRL, v);  chk("R6 pending, mask off", v, 32'h2);
        chk("R6 irq gated by mask", {31'b0, irq_o}, 32'h0);
        wr(I_CTRL, 32'h2);
    endtask

    task automatic t_oor_read();
        logic [31:0] v;
        int a0, w0;
        mmem[24] = pat(7); mmem[25] = pat(8);
        a0 = ax_rd_n + ax_wr_n; w0 = mm_wr_n;
        wr(I_MAIN_W, 32'h0000_0300);
        wr(I_AUX_W, 32'h0100_0000);
        wr(I_LEN_W, 32'h8000_0040);
        wait_idle();
        chk_w("R8 zero fill 0", mmem[24], '0);
        chk_w("R8 zero fill 1", mmem[25], '0);
        chk("R8 no aux access", ax_rd_n + ax_wr_n - a0, 0);
        chk("R8 main writes", mm_wr_n - w0, 2);
        rd(I_CTRL, v);  chk("R8 pending", v, 32'h2);
        rd(I_LEN_W, v); chk("R8 length zero", v, 32'h8000_0000);
        wr(I_CTRL, 32'h2);
    endtask

    task automatic t_oor_write();
        logic [31:0] v;
        int t0;
        t0 = mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n;
        wr(I_MAIN_W, 32'h0000_0400);
        wr(I_AUX_W, 32'h0100_0000);
        wr(I_LEN_W, 32'h0000_0040);
        repeat (20) @(negedge clk);
        rd(I_CTRL, v);  chk("R9 dropped: no busy, no pending", v, 32'h0);
        rd(I_LEN_W, v); chk("R9 length unchanged", v, 32'h0000_0040);
        rd(I_MAIN_W, v); chk("R9 main unchanged", v, 32'h0000_0400);
        chk("R9 no traffic", mm_rd_n + mm_wr_n + ax_rd_n + ax_wr_n + im_wr_n - t0, 0);
    endtask

    task automatic t_magic();
        logic [31:0] v;
        int i0, a0;
        for (int k = 0; k < 8; k++) begin mmem[k] = pat(100 + k); imem[k] = '0; end
        i0 = im_wr_n; a0 = ax_rd_n + ax_wr_n;
        wr(I_MAIN_W, 32'h0100_0000);
        wr(I_AUX_W, 32'h0);
        wr(I_LEN_W, 32'h0000_0040);
        rd(I_LEN_W, v); chk("R10 length cleared", v, 32'h0);
        wait_idle();
        for (int k = 0; k < 8; k++) chk_w("R10 imem chunk", imem[k], pat(100 + k));
        chk("R10 imem write count x4", im_wr_n - i0, 8);
        chk("R10 no aux access", ax_rd_n + ax_wr_n - a0, 0);
        rd(I_MAIN_W, v); chk("R10 main advanced", v, 32'h0100_0100);
        rd(I_CTRL, v);   chk("R10 pending", v, 32'h2);
        wr(I_CTRL, 32'h2);
    endtask

    task automatic t_size_mode();
        logic [31:0] v;
        wr(I_SIZE, 32'hABCD_1234);
        rd(I_SIZE, v); chk("R11 size readback", v, 32'h0000_1234);
        wr(I_MODE, 32'h0);
        rd(I_MODE, v); chk("R11 mode fixed", v, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halves();
        t_zero_len();
        t_main_to_aux();
        t_aux_to_main();
        t_oor_read();
        t_oor_write();
        t_magic();
        t_size_mode();
        chk("R13 one port at a time", multi_n, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule